// File: doc/BRIEF.md
# NAND Flash Device Command Interface Model

This block is a synthesizable behavioural model of the control side of a small NAND flash device. The host drives an 8-bit multiplexed bus with a write strobe, a read strobe, a chip select and two latch qualifiers: one marks a command byte, the other marks an address byte. A byte written with neither qualifier is page data. Every strobe is sampled on the system clock. A write acts on a low-to-high change of the write strobe, and a read acts on a high-to-low change of the read strobe. Both require the chip select to be low.

The model has a paged array and a page register, both held in flops. It decodes the command set and counts address cycles. It keeps a sticky pointer that selects either the main bytes or the spare bytes of each page. It drives a ready line that is low for the whole of each busy period: array-to-register transfer, program, erase and reset. Each busy length is a parameter counted in clock cycles, so a simulation stays short. Status and identification bytes are read through the same output bus as array data.

Top module: `nand_cmd_if`

## Requirements
- R1: Command bytes are decoded as follows:
  - 00h: read, main area.
  - 50h: read, spare area.
  - 80h: start loading data.
  - 10h: commit the loaded data.
  - 60h: prepare an erase. D0h: start the erase.
  - 70h: read status.
  - 90h: read identity.
  - FFh: reset.
  - Any other byte is ignored.
- R2: Read and load each take three address bytes: the column, then the low row byte, then the high row byte. Erase takes only the two row bytes. The page is selected by the low log2(NUM_PAGES) bits of the row. An erase clears the block that holds that page, so the row bits below log2(PAGES_PER_BLOCK) do not matter for an erase.
- R3: After 50h the column becomes 256 plus bits 2..0 of the column byte. Bits 7..3 are ignored. Data loads also use this spare pointer. The pointer stays in effect until a 00h command is written.
- R4: Each read strobe puts the byte at the current column on `bus_out` and advances the column.
  - After column 263, the next page (modulo NUM_PAGES) is selected.
  - The column then restarts at 0 in main mode, or at 256 in spare mode.
  - `ready` drops for T_READ cycles while the next page is transferred.
  - The third address byte of a read also starts a T_READ transfer.
- R5: While busy, only 70h and FFh are acted on; all other bus writes are ignored. A high chip select during a busy period does not shorten or abort it.
- R6: The status byte has this layout:
  - Bit 0: fail flag (1 = failed).
  - Bits 1..5: always 0.
  - Bit 6: ready.
  - Bit 7: the live level of `wp_n`.
  After power-up or reset with `wp_n` high, the status byte reads C0h.
- R7: After 90h and one address byte, the first read returns ECh and the second returns EAh. Any further read returns 00h.
- R8: A 10h written after 80h and at least one data byte starts a busy period of T_PROG cycles. When it ends, each cell becomes its old value AND the loaded byte, so bytes that were not loaded stay unchanged. A 10h written with no data loaded has no effect.
- R9: The sequence 60h, two row bytes, D0h sets every byte of the addressed block to FFh after T_ERASE cycles. Other blocks are unchanged. A D0h written outside that sequence has no effect.
- R10: A commit (10h) or an erase start (D0h) written while `wp_n` is low does not go busy, leaves the array unchanged and sets the fail flag.
- R11: FFh is accepted even while busy. It aborts the current operation without touching the array and is busy for T_RST cycles. It clears the fail flag, selects the main-area read mode and restarts address counting.
- R12: After a commit or an erase start, reads keep returning status until another command is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up state) |
| sel_n | input | 1 | Chip select, active low |
| cmd_le | input | 1 | Marks a write as a command byte |
| adr_le | input | 1 | Marks a write as an address byte |
| wr_n | input | 1 | Write strobe; acts on its rising change |
| rd_n | input | 1 | Read strobe; acts on its falling change |
| wp_n | input | 1 | Write protect, active low |
| bus_in | input | 8 | Command, address or data byte |
| bus_out | output | 8 | Byte returned by the last read strobe |
| ready | output | 1 | High when idle, low while busy |

## Verification
The bench builds the block with four pages of two pages per block. This puts a page wrap, a block boundary and a full array sweep within a few hundred cycles. The busy lengths are 4, 40, 60 and 6 cycles. The 40-cycle program time leaves room to issue a status read, an ignored command and a chip-select release while a program is still running. The short reset time lets a program be cut off by FFh and the untouched cell be checked afterwards.

// File: rtl/nand_cmd_pkg.sv
package nand_cmd_pkg;

   localparam int unsigned PAGE_BYTES = 264;
   localparam int unsigned MAIN_BYTES = 256;
   localparam logic [8:0]  LAST_COL   = 9'd263;

   localparam logic [7:0] C_RD_MAIN  = 8'h00;
   localparam logic [7:0] C_RD_SPARE = 8'h50;
   localparam logic [7:0] C_LOAD     = 8'h80;
   localparam logic [7:0] C_COMMIT   = 8'h10;
   localparam logic [7:0] C_ER_PREP  = 8'h60;
   localparam logic [7:0] C_ER_GO    = 8'hD0;
   localparam logic [7:0] C_STATUS   = 8'h70;
   localparam logic [7:0] C_IDENT    = 8'h90;
   localparam logic [7:0] C_RESET    = 8'hFF;

   typedef enum logic [2:0] {
      MD_READ,
      MD_STATUS,
      MD_IDENT,
      MD_LOAD,
      MD_ERASE
   } mode_t;

   typedef enum logic [1:0] {
      BK_XFER,
      BK_PROG,
      BK_ERASE,
      BK_RST
   } busy_kind_t;

endpackage

// File: rtl/nand_strobe_edge.sv
module nand_strobe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_n,
   input  logic wr_n,
   input  logic rd_n,
   output logic wr_rise,
   output logic rd_fall
);
   logic wr_q, rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= 1'b1;
         rd_q <= 1'b1;
      end else begin
         wr_q <= wr_n;
         rd_q <= rd_n;
      end
   end

   assign wr_rise = wr_n & ~wr_q & ~sel_n;
   assign rd_fall = ~rd_n & rd_q & ~sel_n;
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer
   import nand_cmd_pkg::*;
#(
   parameter int unsigned T_XFER  = 4,
   parameter int unsigned T_PROG  = 40,
   parameter int unsigned T_ERASE = 60,
   parameter int unsigned T_RST   = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  busy_kind_t kind_in,
   output logic       busy,
   output busy_kind_t kind,
   output logic       done
);
   localparam int unsigned TMAX_A = (T_XFER > T_PROG) ? T_XFER : T_PROG;
   localparam int unsigned TMAX_B = (T_ERASE > T_RST) ? T_ERASE : T_RST;
   localparam int unsigned TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
   localparam int unsigned CW     = $clog2(TMAX + 1);

   logic [CW-1:0] cnt;

   function automatic logic [CW-1:0] span(busy_kind_t k);
      case (k)
         BK_XFER:  return CW'(T_XFER - 1);
         BK_PROG:  return CW'(T_PROG - 1);
         BK_ERASE: return CW'(T_ERASE - 1);
         default:  return CW'(T_RST - 1);
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
         kind <= BK_XFER;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= span(kind_in);
         kind <= kind_in;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   assign done = busy && (cnt == '0) && !start;
endmodule

// File: rtl/nand_cmd_if.sv
module nand_cmd_if
   import nand_cmd_pkg::*;
#(
   parameter int unsigned NUM_PAGES       = 4,
   parameter int unsigned PAGES_PER_BLOCK = 2,
   parameter int unsigned T_READ          = 4,
   parameter int unsigned T_PROG          = 40,
   parameter int unsigned T_ERASE         = 60,
   parameter int unsigned T_RST           = 6,
   parameter logic [7:0]  MAKER_CODE      = 8'hEC,
   parameter logic [7:0]  DEVICE_CODE     = 8'hEA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel_n,
   input  logic       cmd_le,
   input  logic       adr_le,
   input  logic       wr_n,
   input  logic       rd_n,
   input  logic       wp_n,
   input  logic [7:0] bus_in,
   output logic [7:0] bus_out,
   output logic       ready
);
   localparam int unsigned PG_BITS   = $clog2(NUM_PAGES);
   localparam int unsigned MEM_DEPTH = NUM_PAGES * PAGE_BYTES;
   localparam int unsigned MW        = $clog2(MEM_DEPTH);

   generate
      if (NUM_PAGES < 2 || NUM_PAGES > 256 || (NUM_PAGES & (NUM_PAGES - 1)) != 0)
         $error("NUM_PAGES must be a power of two from 2 to 256");
      if (PAGES_PER_BLOCK < 1 || PAGES_PER_BLOCK > NUM_PAGES ||
          (PAGES_PER_BLOCK & (PAGES_PER_BLOCK - 1)) != 0)
         $error("PAGES_PER_BLOCK must be a power of two no larger than NUM_PAGES");
      if (T_READ < 1 || T_PROG < 1 || T_ERASE < 1 || T_RST < 1)
         $error("busy lengths must be at least one cycle");
   endgenerate

   logic wr_rise, rd_fall;
   nand_strobe_edge u_edge (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .rd_n(rd_n),
      .wr_rise(wr_rise), .rd_fall(rd_fall)
   );

   logic       is_cmd, is_adr, is_dat;
   assign is_cmd = wr_rise &  cmd_le & ~adr_le;
   assign is_adr = wr_rise & ~cmd_le &  adr_le;
   assign is_dat = wr_rise & ~cmd_le & ~adr_le;

   mode_t              mode;
   logic               spare, fail, loaded;
   logic [1:0]         acnt, id_idx;
   logic [8:0]         col;
   logic [PG_BITS-1:0] page;
   logic [7:0]         preg [PAGE_BYTES];
   logic [7:0]         mem  [MEM_DEPTH];

   logic       t_start, busy, t_done;
   busy_kind_t t_kind_in, t_kind;

   nand_busy_timer #(
      .T_XFER(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_RST(T_RST)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .start(t_start), .kind_in(t_kind_in),
      .busy(busy), .kind(t_kind), .done(t_done)
   );

   assign ready = ~busy;

   always_comb begin
      t_start   = 1'b0;
      t_kind_in = BK_XFER;
      if (is_cmd && bus_in == C_RESET) begin
         t_start   = 1'b1;
         t_kind_in = BK_RST;
      end else if (!busy) begin
         if (is_adr && mode == MD_READ && acnt == 2'd2) begin
            t_start = 1'b1;
         end else if (is_cmd && bus_in == C_COMMIT && mode == MD_LOAD && loaded && wp_n) begin
            t_start   = 1'b1;
            t_kind_in = BK_PROG;
         end else if (is_cmd && bus_in == C_ER_GO && mode == MD_ERASE && acnt == 2'd2 && wp_n) begin
            t_start   = 1'b1;
            t_kind_in = BK_ERASE;
         end else if (rd_fall && mode == MD_READ && acnt == 2'd3 && col == LAST_COL) begin
            t_start = 1'b1;
         end
      end
   end

   int pg_i, blk0;
   always_comb begin
      pg_i = int'(page);
      blk0 = (pg_i / PAGES_PER_BLOCK) * PAGES_PER_BLOCK;
   end

   function automatic logic [MW-1:0] at(int p, int c);
      return MW'(p * PAGE_BYTES + c);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= MD_READ;
         spare   <= 1'b0;
         fail    <= 1'b0;
         loaded  <= 1'b0;
         acnt    <= 2'd0;
         id_idx  <= 2'd0;
         col     <= 9'd0;
         page    <= '0;
         bus_out <= 8'h00;
         for (int c = 0; c < PAGE_BYTES; c++) preg[c] <= 8'hFF;
         for (int m = 0; m < MEM_DEPTH; m++)  mem[m]  <= 8'hFF;
      end else begin
         if (t_done) begin
            case (t_kind)
               BK_XFER:
                  for (int c = 0; c < PAGE_BYTES; c++) preg[c] <= mem[at(pg_i, c)];
               BK_PROG: begin
                  for (int c = 0; c < PAGE_BYTES; c++)
                     mem[at(pg_i, c)] <= mem[at(pg_i, c)] & preg[c];
                  fail <= 1'b0;
               end
               BK_ERASE: begin
                  for (int p = 0; p < PAGES_PER_BLOCK; p++)
                     for (int c = 0; c < PAGE_BYTES; c++) mem[at(blk0 + p, c)] <= 8'hFF;
                  fail <= 1'b0;
               end
               default: ;
            endcase
         end

         if (is_cmd && bus_in == C_RESET) begin
            mode   <= MD_READ;
            spare  <= 1'b0;
            fail   <= 1'b0;
            loaded <= 1'b0;
            acnt   <= 2'd0;
            col    <= 9'd0;
         end else if (is_cmd && busy) begin
            if (bus_in == C_STATUS) mode <= MD_STATUS;
         end else if (is_cmd) begin
            case (bus_in)
               C_RD_MAIN:  begin mode <= MD_READ; spare <= 1'b0; acnt <= 2'd0; col <= 9'd0; end
               C_RD_SPARE: begin mode <= MD_READ; spare <= 1'b1; acnt <= 2'd0; col <= 9'd256; end
               C_IDENT:    begin mode <= MD_IDENT; acnt <= 2'd0; id_idx <= 2'd0; end
               C_ER_PREP:  begin mode <= MD_ERASE; acnt <= 2'd0; end
               C_STATUS:   mode <= MD_STATUS;
               C_LOAD: begin
                  mode   <= MD_LOAD;
                  acnt   <= 2'd0;
                  loaded <= 1'b0;
                  col    <= spare ? 9'd256 : 9'd0;
                  for (int c = 0; c < PAGE_BYTES; c++) preg[c] <= 8'hFF;
               end
               C_COMMIT:
                  if (mode == MD_LOAD && loaded) begin
                     mode <= MD_STATUS;
                     if (!wp_n) fail <= 1'b1;
                  end
               C_ER_GO:
                  if (mode == MD_ERASE && acnt == 2'd2) begin
                     mode <= MD_STATUS;
                     if (!wp_n) fail <= 1'b1;
                  end
               default: ;
            endcase
         end else if (is_adr && !busy) begin
            if (mode == MD_READ || mode == MD_LOAD) begin
               case (acnt)
                  2'd0:    col  <= spare ? {6'b100000, bus_in[2:0]} : {1'b0, bus_in};
                  2'd1:    page <= bus_in[PG_BITS-1:0];
                  default: ;
               endcase
               if (acnt != 2'd3) acnt <= acnt + 2'd1;
            end else if (mode == MD_ERASE) begin
               if (acnt == 2'd0) page <= bus_in[PG_BITS-1:0];
               if (acnt != 2'd2) acnt <= acnt + 2'd1;
            end else if (mode == MD_IDENT) begin
               id_idx <= 2'd0;
            end
         end else if (is_dat && !busy && mode == MD_LOAD && acnt == 2'd3 && col < 9'd264) begin
            preg[col] <= bus_in;
            col       <= col + 9'd1;
            loaded    <= 1'b1;
         end

         if (rd_fall) begin
            case (mode)
               MD_STATUS: bus_out <= {wp_n, ~busy, 5'b00000, fail};
               MD_IDENT: begin
                  bus_out <= (id_idx == 2'd0) ? MAKER_CODE :
                             (id_idx == 2'd1) ? DEVICE_CODE : 8'h00;
                  if (id_idx != 2'd2) id_idx <= id_idx + 2'd1;
               end
               MD_READ:
                  if (!busy && acnt == 2'd3) begin
                     bus_out <= preg[col];
                     if (col == LAST_COL) begin
                        page <= page + 1'b1;
                        col  <= spare ? 9'd256 : 9'd0;
                     end else begin
                        col <= col + 9'd1;
                     end
                  end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/nand_cmd_if_chk.sv
module nand_cmd_if_chk
   import nand_cmd_pkg::*;
#(
   parameter logic [7:0] MAKER_CODE  = 8'hEC,
   parameter logic [7:0] DEVICE_CODE = 8'hEA
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_rise,
   input logic       rd_fall,
   input logic       cmd_le,
   input logic       adr_le,
   input logic [7:0] bus_in,
   input logic       wp_n,
   input logic       busy,
   input logic       fail,
   input logic       loaded,
   input mode_t      mode,
   input logic       spare,
   input logic [1:0] acnt,
   input logic [8:0] col,
   input logic [7:0] bus_out
);
   logic cmd_w;
   assign cmd_w = wr_rise && cmd_le && !adr_le;

   // R2: an erase never counts more than its two row bytes
   a_r2_erase_two_rows: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_ERASE) |-> (acnt <= 2'd2));

   // R3: in spare read mode the column stays in the spare window
   a_r3_spare_window: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_READ && spare) |-> (col >= 9'd256 && col <= 9'd263));

   // R4: in main read mode the column never leaves the page
   a_r4_col_in_page: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_READ) |-> (col <= 9'd263));

   // R5: while busy, commands other than status and reset leave the mode alone
   a_r5_busy_filter: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_w && bus_in != C_STATUS && bus_in != C_RESET)
      |=> ($stable(mode) && $stable(spare)));

   // R6: status bits 1..5 are zero, bit 6 is ready, bit 7 follows wp_n
   a_r6_status_layout: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fall && mode == MD_STATUS)
      |=> (bus_out[5:1] == 5'd0 && bus_out[6] == $past(!busy) && bus_out[7] == $past(wp_n)));

   // R7: identity reads return only the two codes or zero
   a_r7_ident_codes: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fall && mode == MD_IDENT)
      |=> (bus_out == MAKER_CODE || bus_out == DEVICE_CODE || bus_out == 8'h00));

   // R8: a commit with nothing loaded does not go busy
   a_r8_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_w && bus_in == C_COMMIT && !(mode == MD_LOAD && loaded)) |=> !busy);

   // R10: a protected commit sets the fail flag and does not go busy
   a_r10_protected_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_w && bus_in == C_COMMIT && mode == MD_LOAD && loaded && !wp_n)
      |=> (!busy && fail));
endmodule

bind nand_cmd_if nand_cmd_if_chk #(
   .MAKER_CODE(MAKER_CODE), .DEVICE_CODE(DEVICE_CODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_rise(wr_rise), .rd_fall(rd_fall),
   .cmd_le(cmd_le), .adr_le(adr_le), .bus_in(bus_in), .wp_n(wp_n),
   .busy(busy), .fail(fail), .loaded(loaded), .mode(mode), .spare(spare),
   .acnt(acnt), .col(col), .bus_out(bus_out)
);

// File: tb/tb_nand_cmd_if.sv
module tb_nand_cmd_if;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel_n = 1'b0, cle = 1'b0, ale = 1'b0, wr_n = 1'b1, rd_n = 1'b1, wp_n = 1'b1;
   logic [7:0] bus = 8'h00;
   logic [7:0] dout;
   logic       ready;
   int         checks = 0, fails = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   nand_cmd_if #(
      .NUM_PAGES(4), .PAGES_PER_BLOCK(2), .T_READ(4), .T_PROG(40), .T_ERASE(60), .T_RST(6)
   ) dut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cmd_le(cle), .adr_le(ale),
      .wr_n(wr_n), .rd_n(rd_n), .wp_n(wp_n), .bus_in(bus), .bus_out(dout), .ready(ready)
   );

   localparam logic [3:0] OC = 4'd1, OA = 4'd2, OD = 4'd3, OR = 4'd4, OW = 4'd5;
   localparam int TN = 45;
   // entry: {requirement, op, value, expected}
   localparam logic [23:0] TBL [TN] = '{
      // R8 load two bytes into page 1, columns 5 and 6, then commit
      {4'd8, OC, 8'h80, 8'h00}, {4'd2, OA, 8'h05, 8'h00}, {4'd2, OA, 8'h01, 8'h00},
      {4'd2, OA, 8'h00, 8'h00}, {4'd8, OD, 8'hA5, 8'h00}, {4'd8, OD, 8'h3C, 8'h00},
      {4'd8, OC, 8'h10, 8'h00},
      // R5 status while busy, then an ignored read command
      {4'd5, OC, 8'h70, 8'h00}, {4'd5, OR, 8'h00, 8'h80}, {4'd5, OC, 8'h00, 8'h00},
      {4'd5, OR, 8'h00, 8'h80}, {4'd5, OW, 8'h00, 8'h00}, {4'd12, OR, 8'h00, 8'hC0},
      // R1 R4 main read from column 4
      {4'd1, OC, 8'h00, 8'h00}, {4'd2, OA, 8'h04, 8'h00}, {4'd2, OA, 8'h01, 8'h00},
      {4'd2, OA, 8'h00, 8'h00}, {4'd4, OW, 8'h00, 8'h00}, {4'd4, OR, 8'h00, 8'hFF},
      {4'd8, OR, 8'h00, 8'hA5}, {4'd8, OR, 8'h00, 8'h3C}, {4'd4, OR, 8'h00, 8'hFF},
      // R3 spare load at column 259 of page 1 (column byte 0Bh, upper bits ignored)
      {4'd3, OC, 8'h50, 8'h00}, {4'd3, OC, 8'h80, 8'h00}, {4'd3, OA, 8'h0B, 8'h00},
      {4'd2, OA, 8'h01, 8'h00}, {4'd2, OA, 8'h00, 8'h00}, {4'd3, OD, 8'h11, 8'h00},
      {4'd3, OD, 8'h22, 8'h00}, {4'd8, OC, 8'h10, 8'h00}, {4'd8, OW, 8'h00, 8'h00},
      {4'd12, OR, 8'h00, 8'hC0},
      // R3 R4 spare read from page 0 column 262, wrapping into page 1 spare
      {4'd3, OC, 8'h50, 8'h00}, {4'd3, OA, 8'hFE, 8'h00}, {4'd2, OA, 8'h00, 8'h00},
      {4'd2, OA, 8'h00, 8'h00}, {4'd4, OW, 8'h00, 8'h00}, {4'd3, OR, 8'h00, 8'hFF},
      {4'd3, OR, 8'h00, 8'hFF}, {4'd4, OW, 8'h00, 8'h00}, {4'd4, OR, 8'h00, 8'hFF},
      {4'd4, OR, 8'h00, 8'hFF}, {4'd4, OR, 8'h00, 8'hFF}, {4'd3, OR, 8'h00, 8'h11},
      {4'd3, OR, 8'h00, 8'h22}
   };

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic c, input logic a, input logic [7:0] v);
      @(negedge clk); cle = c; ale = a; bus = v; wr_n = 1'b0;
      @(negedge clk); wr_n = 1'b1;
      @(negedge clk); cle = 1'b0; ale = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] v); wr(1'b1, 1'b0, v); endtask
   task automatic adr(input logic [7:0] v); wr(1'b0, 1'b1, v); endtask
   task automatic dat(input logic [7:0] v); wr(1'b0, 1'b0, v); endtask

   task automatic rd(input logic [7:0] exp, input string tag);
      @(negedge clk); rd_n = 1'b0;
      @(negedge clk); rd_n = 1'b1;
      chk(dout == exp, tag, dout, exp);
   endtask

   task automatic wait_rdy(input string tag);
      int n = 0;
      while (!ready && n < 2000) begin @(negedge clk); n++; end
      if (!ready) chk(1'b0, tag, 8'h00, 8'h01);
   endtask

   task automatic hold_ready(input string tag);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(ready == 1'b1, tag, {7'd0, ready}, 8'h01);
      end
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "R4 watchdog", 8'h00, 8'h01);
         report();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 R6 power-up state
      chk(ready == 1'b1, "R11 ready after reset", {7'd0, ready}, 8'h01);
      cmd(8'h70);
      rd(8'hC0, "R6 status after reset");

      for (int i = 0; i < TN; i++) begin
         logic [23:0] e;
         string t;
         e = TBL[i];
         t = $sformatf("R%0d table step %0d", e[23:20], i);
         case (e[19:16])
            OC: cmd(e[15:8]);
            OA: adr(e[15:8]);
            OD: dat(e[15:8]);
            OR: rd(e[7:0], t);
            default: wait_rdy(t);
         endcase
      end

      // R7 identity bytes
      cmd(8'h90); adr(8'h00);
      rd(8'hEC, "R7 maker"); rd(8'hEA, "R7 device"); rd(8'h00, "R7 beyond");

      // R9 R2: page 2 column 0 = 77h, then erase the block of page 1 (row 01h)
      cmd(8'h00); cmd(8'h80); adr(8'h00); adr(8'h02); adr(8'h00); dat(8'h77); cmd(8'h10);
      wait_rdy("R8 program page 2");
      cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'hD0);
      @(negedge clk);
      chk(ready == 1'b0, "R9 erase busy", {7'd0, ready}, 8'h00);
      wait_rdy("R9 erase");
      rd(8'hC0, "R12 status after erase");
      cmd(8'h00); adr(8'h05); adr(8'h01); adr(8'h00); wait_rdy("R9 read");
      rd(8'hFF, "R9 erased byte");
      cmd(8'h00); adr(8'h00); adr(8'h02); adr(8'h00); wait_rdy("R9 read");
      rd(8'h77, "R9 other block kept");

      // R4 main wrap: page 1 column 0 = 5Ch, read page 0 from column 254
      cmd(8'h80); adr(8'h00); adr(8'h01); adr(8'h00); dat(8'h5C); cmd(8'h10);
      wait_rdy("R8 program page 1");
      cmd(8'h00); adr(8'hFE); adr(8'h00); adr(8'h00); wait_rdy("R4 read");
      for (int k = 0; k < 10; k++) rd(8'hFF, "R4 page 0 tail");
      chk(ready == 1'b0, "R4 busy after last column", {7'd0, ready}, 8'h00);
      wait_rdy("R4 wrap");
      rd(8'h5C, "R4 next page column 0");

      // R8 commit with no data, R9 start with no setup: no busy
      cmd(8'h00); cmd(8'h10);
      hold_ready("R8 empty commit");
      cmd(8'hD0);
      hold_ready("R9 lone erase start");

      // R5 chip select high during program does not abort
      cmd(8'h80); adr(8'h01); adr(8'h03); adr(8'h00); dat(8'h42); cmd(8'h10);
      @(negedge clk); sel_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(ready == 1'b0, "R5 still busy with select high", {7'd0, ready}, 8'h00);
      sel_n = 1'b0;
      wait_rdy("R5 program");
      cmd(8'h00); adr(8'h01); adr(8'h03); adr(8'h00); wait_rdy("R5 read");
      rd(8'h42, "R5 program completed");

      // R11 reset aborts a program
      cmd(8'h80); adr(8'h00); adr(8'h03); adr(8'h00); dat(8'h00); cmd(8'h10);
      cmd(8'hFF);
      wait_rdy("R11 reset");
      cmd(8'h70); rd(8'hC0, "R11 status after reset");
      cmd(8'h00); adr(8'h00); adr(8'h03); adr(8'h00); wait_rdy("R11 read");
      rd(8'hFF, "R11 aborted byte untouched");
      // R11 reset returns to main read mode with address count restarted
      cmd(8'h50); cmd(8'hFF); wait_rdy("R11 reset");
      adr(8'h01); adr(8'h03); adr(8'h00); wait_rdy("R11 read");
      rd(8'h42, "R11 main mode after reset");

      // R10 write protect
      wp_n = 1'b0;
      cmd(8'h70); rd(8'h40, "R6 protect bit");
      cmd(8'h80); adr(8'h02); adr(8'h03); adr(8'h00); dat(8'h00); cmd(8'h10);
      hold_ready("R10 protected commit");
      rd(8'h41, "R10 fail flag after commit");
      cmd(8'hFF); wait_rdy("R11 reset");
      cmd(8'h60); adr(8'h06); adr(8'h00); cmd(8'hD0);
      hold_ready("R10 protected erase");
      rd(8'h41, "R10 fail flag after erase");
      wp_n = 1'b1;
      cmd(8'h00); adr(8'h01); adr(8'h03); adr(8'h00); wait_rdy("R10 read");
      rd(8'h42, "R10 block kept");
      rd(8'hFF, "R10 protected byte unchanged");

      done = 1'b1;
      report();
      $finish;
   end
endmodule